// File: doc/BRIEF.md
# DS3 C-bit and X-bit Status Monitor

This block watches the overhead bits of a received DS3 M-frame and keeps persistent alarm and indication flags derived from them. A framer upstream marks each overhead bit with a strobe: an X-bit strobe for the two X bits, and a C-bit strobe that carries the subframe number (0 to 6) and the bit position inside the subframe (0 to 2). A frame-start strobe closes the frame that was being collected and opens the next one. The received bit itself arrives on a single serial input, valid whenever a strobe is high.

At each frame boundary, the block judges the finished frame against several conditions. It counts runs of consecutive frames for each one, and sets or clears a flag when a run reaches its length. Each flag has its own asymmetric rule. The flags are: C bits all zero, remote alarm indication from the X bits, C-bit-parity identification from the first C bit, and seven loopback-request flags, one per subframe, which apply only in M23 mode. The all-zero flag is the only one that can clear in the middle of a frame: one all-ones subframe drops it at once.

Top module: `ds3_cx_monitor`

## Requirements
- R1: After reset, `cbz_det`, `rai_det`, `c1_det` and all bits of `lb_det` are 0.
- R2: `cbz_det` goes to 1 in the cycle after the frame-start strobe that closes the third consecutive frame in which all 21 C bits were received as 0. A frame with any C bit at 1 restarts the count.
- R3: While `cbz_det` is 1, it goes to 0 in the cycle after bit position 2 of a subframe is strobed as 1, provided positions 0 and 1 of that same subframe were received as 1 in the current frame. A subframe pattern with a 0 in any position does not clear it.
- R4: `rai_det` goes to 1 after 2 consecutive frames in which both X bits are 0. A frame that breaks the condition restarts the count.
- R5: Once set, `rai_det` goes to 0 only after 2 consecutive frames with both X bits at 1. A frame with mixed X bits restarts that count and leaves the flag unchanged.
- R6: `c1_det` goes to 1 after 8 consecutive frames in which the first C bit (subframe 0, position 0) is 1. A single frame with that bit at 0 restarts the count.
- R7: Once set, `c1_det` goes to 0 after 3 consecutive frames in which the first C bit is 0.
- R8: With `mode_m23` = 1, `lb_det[y]` goes to 1 after 5 consecutive frames in which, for subframe y, positions 0 and 1 are equal and position 2 differs from them. Each subframe counts on its own.
- R9: With `mode_m23` = 1, a set `lb_det[y]` goes to 0 after 5 consecutive frames in which all three C bits of subframe y are equal. A frame in which they are neither equal nor a loopback pattern restarts the count.
- R10: While `mode_m23` = 0, `lb_det` is all zeros from the next cycle on, and the loopback run counts are reset. After a return to M23 mode, a full run of 5 frames is needed again.
- R11: The first frame-start strobe after reset only opens a frame, and bits strobed before it are discarded. Apart from the R3 clear, flags change only in the cycle after a frame-start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received serial bit, valid with a strobe |
| x_stb | input | 1 | Current bit is an X bit |
| c_stb | input | 1 | Current bit is a C bit |
| c_sub | input | 3 | Subframe index of the C bit, 0 to 6 |
| c_idx | input | 2 | Position of the C bit inside its subframe, 0 to 2 |
| frm_start | input | 1 | Frame boundary: closes the current frame and opens the next |
| mode_m23 | input | 1 | 1 = M23 mode (loopback detect active), 0 = C-bit parity mode |
| cbz_det | output | 1 | All C bits zero detected |
| rai_det | output | 1 | Remote alarm indication from the X bits |
| c1_det | output | 1 | C-bit-parity identification from the first C bit |
| lb_det | output | 7 | Loopback request per subframe, bit y = subframe y |

## Verification
Remote-alarm set and C-bit-parity identification set can land on the same frame boundary, because both are judged from one frame's bits in one evaluation cycle. The bench provokes this with eight frames that carry the first C bit as 1 and whose last two frames also carry both X bits as 0. After the seventh frame it requires both flags low, and after the eighth it requires both high in the same sampled cycle. A second pairing is a mid-frame all-zero clear in a frame that then also closes a run. The bench checks that the clear appears right after the third subframe bit and that the later boundary does not revive the flag.

// File: rtl/ds3_cx_pkg.sv
package ds3_cx_pkg;
    localparam int NSUB   = 7;
    localparam int CPER   = 3;
    localparam int NCB    = NSUB * CPER;
    localparam int SUBW   = $clog2(NSUB);
    localparam int IDXW   = $clog2(CPER);
    localparam int POSW   = $clog2(NCB);

    typedef struct packed {
        logic [NCB-1:0] c_val;
        logic [NCB-1:0] c_seen;
        logic [1:0]     x_cnt;
        logic [1:0]     x_ones;
        logic           open;
    } col_state_t;
endpackage

// File: rtl/cx_frame_collect.sv
module cx_frame_collect
    import ds3_cx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_bit,
    input  logic            x_stb,
    input  logic            c_stb,
    input  logic [SUBW-1:0] c_sub,
    input  logic [IDXW-1:0] c_idx,
    input  logic            frm_start,
    output logic            frame_tick,
    output logic            fr_czero,
    output logic            fr_x0,
    output logic            fr_x1,
    output logic            fr_c1_one,
    output logic            fr_c1_zero,
    output logic [NSUB-1:0] fr_sub_diff,
    output logic [NSUB-1:0] fr_sub_same,
    output logic            ones_pulse
);
    col_state_t st_d, st_q;
    logic [POSW-1:0] pos;
    logic            pos_ok;
    logic [POSW-1:0] base;

    assign pos    = POSW'(c_sub) * POSW'(CPER) + POSW'(c_idx);
    assign pos_ok = (int'(c_sub) < NSUB) && (int'(c_idx) < CPER);
    assign base   = POSW'(c_sub) * POSW'(CPER);

    always_comb begin
        st_d = st_q;
        if (frm_start) begin
            st_d.c_val  = '0;
            st_d.c_seen = '0;
            st_d.x_cnt  = '0;
            st_d.x_ones = '0;
            st_d.open   = 1'b1;
        end else begin
            if (c_stb && pos_ok) begin
                st_d.c_seen[pos] = 1'b1;
                st_d.c_val[pos]  = rx_bit;
            end
            if (x_stb && st_q.x_cnt != 2'd2) begin
                st_d.x_cnt  = st_q.x_cnt + 2'd1;
                st_d.x_ones = st_q.x_ones + {1'b0, rx_bit};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_tick = frm_start && st_q.open;
    assign fr_czero   = (&st_q.c_seen) && ~(|st_q.c_val);
    assign fr_x0      = (st_q.x_cnt == 2'd2) && (st_q.x_ones == 2'd0);
    assign fr_x1      = (st_q.x_cnt == 2'd2) && (st_q.x_ones == 2'd2);
    assign fr_c1_one  = st_q.c_seen[0] && st_q.c_val[0];
    assign fr_c1_zero = st_q.c_seen[0] && !st_q.c_val[0];

    for (genvar y = 0; y < NSUB; y++) begin : g_sub
        logic       all_seen;
        logic [2:0] v;
        assign all_seen = &st_q.c_seen[y*CPER +: CPER];
        assign v        = st_q.c_val[y*CPER +: CPER];
        assign fr_sub_diff[y] = all_seen && (v[0] == v[1]) && (v[2] != v[0]);
        assign fr_sub_same[y] = all_seen && (v[0] == v[1]) && (v[2] == v[0]);
    end

    assign ones_pulse = c_stb && pos_ok && !frm_start && (int'(c_idx) == CPER - 1)
                     && rx_bit
                     && st_q.c_seen[base] && st_q.c_val[base]
                     && st_q.c_seen[base + POSW'(1)] && st_q.c_val[base + POSW'(1)];

    a_r11_xcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.x_ones <= st_q.x_cnt);
endmodule

// File: rtl/cx_persist.sv
module cx_persist #(
    parameter int SET_N = 3,
    parameter int CLR_N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_tick,
    input  logic set_cond,
    input  logic clr_cond,
    input  logic force_clr,
    output logic flag
);
    localparam int MAXN = (SET_N > CLR_N) ? SET_N : CLR_N;
    localparam int CW   = $clog2(MAXN + 1);

    typedef struct packed {
        logic          flag;
        logic [CW-1:0] run;
    } pst_t;

    pst_t          st_d, st_q;
    logic          cond;
    logic [CW-1:0] lim;
    logic [CW-1:0] nxt;

    always_comb begin
        st_d = st_q;
        cond = st_q.flag ? clr_cond : set_cond;
        lim  = st_q.flag ? CW'(CLR_N) : CW'(SET_N);
        nxt  = st_q.run + CW'(1);
        if (force_clr) begin
            st_d.flag = 1'b0;
            st_d.run  = '0;
        end else if (frame_tick) begin
            if (cond) begin
                if (nxt >= lim) begin
                    st_d.flag = !st_q.flag;
                    st_d.run  = '0;
                end else begin
                    st_d.run = nxt;
                end
            end else begin
                st_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    a_r11_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_tick || force_clr) |=> $stable(flag));
    a_r11_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.run) < MAXN);
    a_r10_force_clear: assert property (@(posedge clk) disable iff (!rst_n)
        force_clr |=> !flag);
endmodule

// File: rtl/ds3_cx_monitor.sv
module ds3_cx_monitor
    import ds3_cx_pkg::*;
#(
    parameter int CBZ_SET_FR = 3,
    parameter int RAI_SET_FR = 2,
    parameter int RAI_CLR_FR = 2,
    parameter int C1_SET_FR  = 8,
    parameter int C1_CLR_FR  = 3,
    parameter int LB_FR      = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_bit,
    input  logic            x_stb,
    input  logic            c_stb,
    input  logic [2:0]      c_sub,
    input  logic [1:0]      c_idx,
    input  logic            frm_start,
    input  logic            mode_m23,
    output logic            cbz_det,
    output logic            rai_det,
    output logic            c1_det,
    output logic [6:0]      lb_det
);
    logic            frame_tick;
    logic            fr_czero, fr_x0, fr_x1, fr_c1_one, fr_c1_zero;
    logic [NSUB-1:0] fr_sub_diff, fr_sub_same;
    logic            ones_pulse;
    logic [NSUB-1:0] lb_flags;

    cx_frame_collect u_col (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit),
        .x_stb(x_stb), .c_stb(c_stb),
        .c_sub(c_sub[SUBW-1:0]), .c_idx(c_idx[IDXW-1:0]),
        .frm_start(frm_start), .frame_tick(frame_tick),
        .fr_czero(fr_czero), .fr_x0(fr_x0), .fr_x1(fr_x1),
        .fr_c1_one(fr_c1_one), .fr_c1_zero(fr_c1_zero),
        .fr_sub_diff(fr_sub_diff), .fr_sub_same(fr_sub_same),
        .ones_pulse(ones_pulse)
    );

    cx_persist #(.SET_N(CBZ_SET_FR), .CLR_N(1)) u_cbz (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .set_cond(fr_czero), .clr_cond(1'b0), .force_clr(ones_pulse),
        .flag(cbz_det)
    );

    cx_persist #(.SET_N(RAI_SET_FR), .CLR_N(RAI_CLR_FR)) u_rai (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .set_cond(fr_x0), .clr_cond(fr_x1), .force_clr(1'b0),
        .flag(rai_det)
    );

    cx_persist #(.SET_N(C1_SET_FR), .CLR_N(C1_CLR_FR)) u_c1 (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .set_cond(fr_c1_one), .clr_cond(fr_c1_zero), .force_clr(1'b0),
        .flag(c1_det)
    );

    for (genvar y = 0; y < NSUB; y++) begin : g_lb
        cx_persist #(.SET_N(LB_FR), .CLR_N(LB_FR)) u_lb (
            .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
            .set_cond(fr_sub_diff[y]), .clr_cond(fr_sub_same[y]),
            .force_clr(!mode_m23), .flag(lb_flags[y])
        );
    end

    assign lb_det = lb_flags;

    // R3: an all-ones subframe drops the all-zero flag on the next cycle
    a_r3_cbz_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ones_pulse |=> !cbz_det);
    a_r2_cbz_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cbz_det) |-> $past(frame_tick));
    a_r6_c1_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c1_det) |-> $past(frame_tick));
    a_r4_rai_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rai_det) |-> $past(frame_tick));
    a_r10_lb_held: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_m23 |=> lb_det == '0);
endmodule

// File: tb/ds3_cx_monitor_bench.sv
module ds3_cx_monitor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0, x_stb = 1'b0, c_stb = 1'b0, frm_start = 1'b0;
    logic [2:0] c_sub = '0;
    logic [1:0] c_idx = '0;
    logic       mode_m23 = 1'b0;
    logic       cbz_det, rai_det, c1_det;
    logic [6:0] lb_det;

    int errors = 0;
    int checks = 0;
    logic cbz_pre, cbz_post;

    always #2.5 clk = ~clk;

    ds3_cx_monitor u_ds3_cx_monitor (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .x_stb(x_stb), .c_stb(c_stb),
        .c_sub(c_sub), .c_idx(c_idx), .frm_start(frm_start), .mode_m23(mode_m23),
        .cbz_det(cbz_det), .rai_det(rai_det), .c1_det(c1_det), .lb_det(lb_det)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe_x(input logic b);
        @(negedge clk); x_stb = 1'b1; rx_bit = b;
        @(negedge clk); x_stb = 1'b0; rx_bit = 1'b0;
    endtask

    task automatic strobe_c(input int s, input int i, input logic b);
        @(negedge clk); c_stb = 1'b1; c_sub = 3'(s); c_idx = 2'(i); rx_bit = b;
        @(negedge clk); c_stb = 1'b0; rx_bit = 1'b0;
    endtask

    task automatic boundary();
        @(negedge clk); frm_start = 1'b1;
        @(negedge clk); frm_start = 1'b0;
    endtask

    // bit s*3+i of cb is position i of subframe s
    task automatic send_frame(input logic [20:0] cb, input logic [1:0] xb, input int watch);
        strobe_x(xb[0]);
        strobe_x(xb[1]);
        for (int s = 0; s < 7; s++) begin
            for (int i = 0; i < 3; i++) begin
                strobe_c(s, i, cb[s*3+i]);
                if (s == watch && i == 1) cbz_pre = cbz_det;
                if (s == watch && i == 2) cbz_post = cbz_det;
            end
        end
        boundary();
    endtask

    task automatic do_reset(input logic m);
        mode_m23 = m;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        boundary();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cbz", cbz_det, 0);
        chk("R1 rai", rai_det, 0);
        chk("R1 c1", c1_det, 0);
        chk("R1 lb", lb_det, 0);
        // R11: bits before the first boundary are discarded
        strobe_x(1'b0); strobe_x(1'b0);
        boundary();
        chk("R11 open only", rai_det, 0);
        send_frame(21'h0, 2'b00, -1);
        chk("R11 one frame", rai_det, 0);
        send_frame(21'h0, 2'b00, -1);
        chk("R11 two frames", rai_det, 1);
    endtask

    task automatic t_cbz();
        do_reset(1'b0);
        send_frame(21'h0, 2'b01, -1);
        send_frame(21'h0, 2'b01, -1);
        chk("R2 two frames", cbz_det, 0);
        send_frame(21'h1 << 13, 2'b01, -1);
        send_frame(21'h0, 2'b01, -1);
        send_frame(21'h0, 2'b01, -1);
        chk("R2 restart", cbz_det, 0);
        send_frame(21'h0, 2'b01, -1);
        chk("R2 set", cbz_det, 1);
        send_frame(21'h3 << 12, 2'b01, 4);
        chk("R3 partial keeps", cbz_post, 1);
        chk("R3 partial frame", cbz_det, 1);
        send_frame(21'h7 << 12, 2'b01, 4);
        chk("R3 before third", cbz_pre, 1);
        chk("R3 after third", cbz_post, 0);
        chk("R3 stays clear", cbz_det, 0);
    endtask

    task automatic t_rai();
        do_reset(1'b0);
        send_frame(21'h0, 2'b00, -1);
        send_frame(21'h0, 2'b10, -1);
        send_frame(21'h0, 2'b00, -1);
        chk("R4 restart", rai_det, 0);
        send_frame(21'h0, 2'b00, -1);
        chk("R4 set", rai_det, 1);
        send_frame(21'h0, 2'b11, -1);
        send_frame(21'h0, 2'b01, -1);
        send_frame(21'h0, 2'b11, -1);
        chk("R5 restart", rai_det, 1);
        send_frame(21'h0, 2'b11, -1);
        chk("R5 clear", rai_det, 0);
    endtask

    task automatic t_c1();
        do_reset(1'b0);
        repeat (7) send_frame(21'h1, 2'b01, -1);
        send_frame(21'h0, 2'b01, -1);
        repeat (7) send_frame(21'h1, 2'b01, -1);
        chk("R6 seven", c1_det, 0);
        send_frame(21'h1, 2'b01, -1);
        chk("R6 set", c1_det, 1);
        repeat (2) send_frame(21'h0, 2'b01, -1);
        send_frame(21'h1, 2'b01, -1);
        repeat (2) send_frame(21'h0, 2'b01, -1);
        chk("R7 restart", c1_det, 1);
        send_frame(21'h0, 2'b01, -1);
        chk("R7 clear", c1_det, 0);
    endtask

    task automatic t_lb();
        logic [20:0] d2, d5;
        d2 = 21'h1 << 8;
        d5 = 21'h1 << 17;
        do_reset(1'b1);
        send_frame(d2, 2'b01, -1);
        send_frame(d2, 2'b01, -1);
        send_frame(d2 | d5, 2'b01, -1);
        send_frame(d2 | d5, 2'b01, -1);
        chk("R8 four", lb_det, 7'h00);
        send_frame(d2 | d5, 2'b01, -1);
        chk("R8 sub2 set", lb_det, 7'h04);
        send_frame(d2 | d5, 2'b01, -1);
        chk("R8 independent", lb_det, 7'h04);
        send_frame(d2 | d5, 2'b01, -1);
        chk("R8 sub5 set", lb_det, 7'h24);
        repeat (4) send_frame(d5, 2'b01, -1);
        send_frame(d5 | (21'h1 << 7), 2'b01, -1);
        repeat (4) send_frame(d5, 2'b01, -1);
        chk("R9 restart", lb_det, 7'h24);
        send_frame(d5, 2'b01, -1);
        chk("R9 clear", lb_det, 7'h20);
    endtask

    task automatic t_mode();
        logic [20:0] d2, d5;
        d2 = 21'h1 << 8;
        d5 = 21'h1 << 17;
        do_reset(1'b1);
        repeat (5) send_frame(d5, 2'b01, -1);
        chk("R10 pre", lb_det, 7'h20);
        repeat (3) send_frame(d2 | d5, 2'b01, -1);
        @(negedge clk); mode_m23 = 1'b0;
        @(negedge clk);
        chk("R10 held", lb_det, 7'h00);
        mode_m23 = 1'b1;
        repeat (2) send_frame(d2, 2'b01, -1);
        chk("R10 run reset", lb_det, 7'h00);
        repeat (3) send_frame(d2, 2'b01, -1);
        chk("R10 full run", lb_det, 7'h04);
    endtask

    task automatic t_same_cycle();
        do_reset(1'b0);
        repeat (6) send_frame(21'h1, 2'b01, -1);
        send_frame(21'h1, 2'b00, -1);
        chk("R4 pair pre", rai_det, 0);
        chk("R6 pair pre", c1_det, 0);
        send_frame(21'h1, 2'b00, -1);
        chk("R4 pair", rai_det, 1);
        chk("R6 pair", c1_det, 1);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_cbz();
        t_rai();
        t_c1();
        t_lb();
        t_mode();
        t_same_cycle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule